// File: doc/BRIEF.md
# Watermark FIFO with DMA Requests

This block is a circular word buffer that sits between a host register port and a card-side byte engine. The direction of the current transfer is selected by a single input. In the card-to-host direction the card engine pushes words in and the host reads them out. In the host-to-card direction the host writes words in and the card engine drains them. Storage is `DEPTH` words of `WIDTH` bits, which defaults to 32 x 16. `DEPTH` must be a power of two.

Two programmable thresholds watch the fill level. When the FIFO is filling toward the host, a high-water mark drives either a receive DMA request or a status flag. When the FIFO is draining toward the card, a low-water mark drives either a transmit DMA request or a second status flag. A per-direction DMA enable in the configuration word chooses between the request line and the flag. The two flags are meant to sit at bits 10 (`sts_afull`) and 11 (`sts_aempty`) of a shared status register kept outside this block. The current level is also exported.

The host side is a plain register port that moves one word per strobe. The card side uses valid/ready streams with these back-pressure rules:
- The push stream (`ci_*`) is ready only in the card-to-host direction while the FIFO is not full.
- The drain stream (`co_*`) is valid only in the host-to-card direction while the FIFO is not empty.
- A word moves on a cycle where valid and ready are both high.

Top module: `wm_dma_fifo`

## Requirements
- R1: After reset the level is 0, the high-water mark is 31, the low-water mark is 0, both DMA enables are off, and every request, flag and underrun output is low.
- R2: Words leave in the order they entered. A pushed word goes into slot (start + level) mod DEPTH, the head word is always visible on `hr_data` and `co_data`, and the level follows each accepted push or pop on the next clock edge.
- R3: A host write (`hw_valid` in the host-to-card direction) that arrives while the FIFO holds DEPTH words is discarded. The level and the stored words are unchanged.
- R4: `ci_ready` is high exactly when `dir_rx`=1 and the FIFO is not full. `co_valid` is high exactly when `dir_rx`=0 and the FIFO is not empty. Host writes have no effect when `dir_rx`=1, and host reads have no effect when `dir_rx`=0.
- R5: With `dir_rx`=1 and level greater than the high-water mark, `drq_rx` is high if receive DMA is enabled. Otherwise `sts_afull` is high. The other of the two stays low.
- R6: With `dir_rx`=0 and level less than the low-water mark, `drq_tx` is high if transmit DMA is enabled. Otherwise `sts_aempty` is high. The other of the two stays low.
- R7: When its direction-gated threshold condition does not hold, a direction's request and flag are both low. For example, a full FIFO in the host-to-card direction raises neither `drq_rx` nor `sts_afull`.
- R8: While `busy`=0 and the FIFO is empty, `sts_afull`, `sts_aempty`, `drq_rx` and `drq_tx` are all low, whatever the thresholds are.
- R9: A `cfg_wr` strobe loads the configuration word with this layout:
  - bit 15: receive DMA enable
  - bits 12:8: high-water mark
  - bit 7: transmit DMA enable
  - bits 4:0: low-water mark
  The new values take effect on the next clock edge.
- R10: A host read (`hr_req`, `dir_rx`=1) of an empty FIFO leaves the pointers and level unchanged. `hr_data` keeps showing the stale head slot, and `hr_underrun` pulses high for one cycle after the edge.
- R11: A host pop and a card push accepted in the same cycle leave the level unchanged, and the head advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx | input | 1 | 1: card-to-host, 0: host-to-card |
| busy | input | 1 | Transfer in progress |
| cfg_wr | input | 1 | Load configuration word |
| cfg_word | input | 16 | Configuration word (layout in R9) |
| hw_valid | input | 1 | Host write strobe |
| hw_data | input | WIDTH | Host write word |
| hr_req | input | 1 | Host read strobe (pops the head) |
| hr_data | output | WIDTH | Head word seen by the host |
| hr_underrun | output | 1 | One-cycle pulse after a read of an empty FIFO |
| ci_valid | input | 1 | Card push valid |
| ci_ready | output | 1 | Card push ready |
| ci_data | input | WIDTH | Card push word |
| co_valid | output | 1 | Card drain valid |
| co_ready | input | 1 | Card drain ready |
| co_data | output | WIDTH | Card drain word (head) |
| level | output | $clog2(DEPTH)+1 | Current fill level |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |
| sts_afull | output | 1 | High-water status flag (status bit 10) |
| sts_aempty | output | 1 | Low-water status flag (status bit 11) |

## Verification
The readiness signals and the head word are combinational. They are due in the same cycle as the stimulus, so the bench compares them 1 ns after it drives the inputs and before the rising edge. The level, the four threshold outputs and the underrun pulse change only on the edge that accepts an operation. The bench therefore checks them at the next falling edge against a reference queue that it advances at that same edge. A new configuration word is due one edge after its strobe, and the bench applies it to its reference at that edge as well.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  // Configuration word field positions (decoded by wmf_cfg)
  localparam int CFG_RXEN_BIT = 15;
  localparam int CFG_HI_LSB   = 8;
  localparam int CFG_TXEN_BIT = 7;
  localparam int CFG_LO_LSB   = 0;
  localparam int CFG_W        = 16;

  typedef struct packed {
    logic hpush;
    logic cpush;
    logic hpop;
    logic cpop;
  } wmf_ops_t;
endpackage

// File: rtl/wmf_ring.sv
module wmf_ring #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [LW-1:0]    level,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    start_q;
  logic [LW-1:0]    level_q;
  logic [AW-1:0]    wr_slot;

  assign wr_slot = start_q + level_q[AW-1:0];
  assign level   = level_q;
  assign head    = mem[start_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      level_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) mem[wr_slot] <= push_data;
      if (pop)  start_q <= start_q + 1'b1;
      unique case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(level));
  a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> level == $past(level) - 1'b1);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/wmf_cfg.sv
module wmf_cfg #(
  parameter int TW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [wmf_pkg::CFG_W-1:0] cfg_word,
  output logic                    rx_en,
  output logic                    tx_en,
  output logic [TW-1:0]           hi_mark,
  output logic [TW-1:0]           lo_mark
);
  import wmf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      hi_mark <= '1;
      lo_mark <= '0;
    end else if (cfg_wr) begin
      rx_en   <= cfg_word[CFG_RXEN_BIT];
      tx_en   <= cfg_word[CFG_TXEN_BIT];
      hi_mark <= cfg_word[CFG_HI_LSB +: TW];
      lo_mark <= cfg_word[CFG_LO_LSB +: TW];
    end
  end

  a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> hi_mark == $past(cfg_word[CFG_HI_LSB +: TW]) && rx_en == $past(cfg_word[CFG_RXEN_BIT]));
endmodule

// File: rtl/wmf_watermark.sv
module wmf_watermark #(
  parameter int TW = 5,
  localparam int LW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          dir_rx,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] hi_mark,
  input  logic [TW-1:0] lo_mark,
  input  logic          rx_en,
  input  logic          tx_en,
  output logic          drq_rx,
  output logic          drq_tx,
  output logic          sts_afull,
  output logic          sts_aempty
);
  logic idle, over_hi, under_lo;

  always_comb begin
    idle       = !busy && (level == '0);
    over_hi    = !idle && dir_rx && (level > {1'b0, hi_mark});
    under_lo   = !idle && !dir_rx && (level < {1'b0, lo_mark});
    drq_rx     = over_hi && rx_en;
    sts_afull  = over_hi && !rx_en;
    drq_tx     = under_lo && tx_en;
    sts_aempty = under_lo && !tx_en;
  end

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && level == '0 |-> !sts_afull && !sts_aempty && !drq_rx && !drq_tx);
  a_r5_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(drq_rx && sts_afull));
  a_r7_dir_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rx |-> !drq_tx && !sts_aempty);
endmodule

// File: rtl/wm_dma_fifo.sv
module wm_dma_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int TW = $clog2(DEPTH),
  localparam int LW = TW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_rx,
  input  logic                      busy,
  input  logic                      cfg_wr,
  input  logic [wmf_pkg::CFG_W-1:0] cfg_word,
  input  logic                      hw_valid,
  input  logic [WIDTH-1:0]          hw_data,
  input  logic                      hr_req,
  output logic [WIDTH-1:0]          hr_data,
  output logic                      hr_underrun,
  input  logic                      ci_valid,
  output logic                      ci_ready,
  input  logic [WIDTH-1:0]          ci_data,
  output logic                      co_valid,
  input  logic                      co_ready,
  output logic [WIDTH-1:0]          co_data,
  output logic [LW-1:0]             level,
  output logic                      drq_rx,
  output logic                      drq_tx,
  output logic                      sts_afull,
  output logic                      sts_aempty
);
  import wmf_pkg::*;

  wmf_ops_t         ops;
  logic             full, empty, push, pop, underrun_q;
  logic [WIDTH-1:0] push_data, head;
  logic             rx_en, tx_en;
  logic [TW-1:0]    hi_mark, lo_mark;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    ci_ready  = dir_rx && !full;
    co_valid  = !dir_rx && !empty;
    ops.hpush = hw_valid && !dir_rx && !full;
    ops.cpush = ci_valid && ci_ready;
    ops.hpop  = hr_req && dir_rx && !empty;
    ops.cpop  = co_valid && co_ready;
    push      = ops.hpush || ops.cpush;
    pop       = ops.hpop || ops.cpop;
    push_data = dir_rx ? ci_data : hw_data;
  end

  assign hr_data     = head;
  assign co_data     = head;
  assign hr_underrun = underrun_q;

  always_ff @(posedge clk) begin
    if (!rst_n) underrun_q <= 1'b0;
    else        underrun_q <= hr_req && dir_rx && empty;
  end

  wmf_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .level(level), .head(head)
  );

  wmf_cfg #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .rx_en(rx_en), .tx_en(tx_en), .hi_mark(hi_mark), .lo_mark(lo_mark)
  );

  wmf_watermark #(.TW(TW)) u_wm (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir_rx(dir_rx), .level(level),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .rx_en(rx_en), .tx_en(tx_en),
    .drq_rx(drq_rx), .drq_tx(drq_tx), .sts_afull(sts_afull), .sts_aempty(sts_aempty)
  );

  a_r4_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ci_ready);
  a_r3_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    full && !dir_rx && hw_valid && !co_ready |=> full);
  a_r10_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hr_req && dir_rx && empty && !ci_valid |=> hr_underrun && empty);
endmodule

// File: tb/sim_wm_dma_fifo.sv
module sim_wm_dma_fifo;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_rx = 1'b0, busy = 1'b0, cfg_wr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic hw_valid = 1'b0, hr_req = 1'b0, ci_valid = 1'b0, co_ready = 1'b0;
  logic [WIDTH-1:0] hw_data = '0, ci_data = '0;
  logic [WIDTH-1:0] hr_data, co_data;
  logic hr_underrun, ci_ready, co_valid, drq_rx, drq_tx, sts_afull, sts_aempty;
  logic [5:0] level;

  always #10 clk = ~clk;

  wm_dma_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .busy(busy), .cfg_wr(cfg_wr),
    .cfg_word(cfg_word), .hw_valid(hw_valid), .hw_data(hw_data), .hr_req(hr_req),
    .hr_data(hr_data), .hr_underrun(hr_underrun), .ci_valid(ci_valid),
    .ci_ready(ci_ready), .ci_data(ci_data), .co_valid(co_valid), .co_ready(co_ready),
    .co_data(co_data), .level(level), .drq_rx(drq_rx), .drq_tx(drq_tx),
    .sts_afull(sts_afull), .sts_aempty(sts_aempty)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [WIDTH-1:0] m_mem [DEPTH];
  int m_start = 0, m_cnt = 0;
  bit m_rxen = 0, m_txen = 0;
  int m_hi = 31, m_lo = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected {drq_rx, drq_tx, sts_afull, sts_aempty}
  function automatic logic [3:0] exp_flags(input bit b, input bit d, input int lvl);
    bit idle, over, under;
    idle  = !b && lvl == 0;
    over  = !idle && d && lvl > m_hi;
    under = !idle && !d && lvl < m_lo;
    return {over && m_rxen, under && m_txen, over && !m_rxen, under && !m_txen};
  endfunction

  task automatic tick(input string lt);
    bit full, empty, hpush, cpush, hpop, cpop, und, cw;
    logic [15:0] cwd;
    logic [3:0] ef;
    #1;
    full  = (m_cnt == DEPTH);
    empty = (m_cnt == 0);
    hpush = hw_valid && !dir_rx && !full;
    cpush = ci_valid && dir_rx && !full;
    hpop  = hr_req && dir_rx && !empty;
    cpop  = co_ready && !dir_rx && !empty;
    und   = hr_req && dir_rx && empty;
    cw = cfg_wr; cwd = cfg_word;
    chk("R4 ci_ready", 32'(ci_ready), 32'(dir_rx && !full));
    chk("R4 co_valid", 32'(co_valid), 32'(!dir_rx && !empty));
    if (hpop) chk("R2 hr_data", 32'(hr_data), 32'(m_mem[m_start]));
    if (cpop) chk("R2 co_data", 32'(co_data), 32'(m_mem[m_start]));
    @(posedge clk);
    if (hpush) m_mem[(m_start + m_cnt) % DEPTH] = hw_data;
    if (cpush) m_mem[(m_start + m_cnt) % DEPTH] = ci_data;
    if (hpop || cpop) m_start = (m_start + 1) % DEPTH;
    m_cnt = m_cnt + int'(hpush || cpush) - int'(hpop || cpop);
    if (cw) begin  // R9 layout
      m_rxen = cwd[15]; m_hi = int'(cwd[12:8]);
      m_txen = cwd[7];  m_lo = int'(cwd[4:0]);
    end
    @(negedge clk);
    chk(lt, 32'(level), 32'(m_cnt));
    ef = exp_flags(busy, dir_rx, m_cnt);
    chk("R5 drq_rx", 32'(drq_rx), 32'(ef[3]));
    chk("R6 drq_tx", 32'(drq_tx), 32'(ef[2]));
    chk("R5 sts_afull", 32'(sts_afull), 32'(ef[1]));
    chk("R6 sts_aempty", 32'(sts_aempty), 32'(ef[0]));
    chk("R10 underrun", 32'(hr_underrun), 32'(und));
  endtask

  task automatic idle_ins();
    hw_valid = 0; hr_req = 0; ci_valid = 0; co_ready = 0; cfg_wr = 0;
  endtask

  task automatic set_cfg(input logic [15:0] w);
    idle_ins(); cfg_wr = 1; cfg_word = w;
    tick("R9 level");
    cfg_wr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 level", 32'(level), 0);
    chk("R1 flags", 32'({drq_rx, drq_tx, sts_afull, sts_aempty, hr_underrun}), 0);

    // R1: default high mark 31 -> afull only at 32 words
    busy = 1; dir_rx = 1;
    for (int i = 0; i < 31; i++) begin
      ci_valid = 1; ci_data = 16'h1000 + 16'(i); tick("R2 level");
    end
    chk("R1 afull off at 31", 32'(sts_afull), 0);
    ci_data = 16'h101F; tick("R2 level");
    chk("R1 afull on at 32", 32'(sts_afull), 1);
    chk("R4 ready low when full", 32'(ci_ready), 0);
    // R7: full FIFO in host-to-card direction raises no rx outputs
    idle_ins(); dir_rx = 0; #1;
    chk("R7 no afull in tx dir", 32'({drq_rx, sts_afull}), 0);
    // R3: host write to full FIFO discarded
    hw_valid = 1; hw_data = 16'hDEAD; tick("R3 level");
    chk("R3 full kept", 32'(level), 32);
    // drain in order, R2
    idle_ins(); co_ready = 1;
    for (int i = 0; i < 32; i++) begin
      #1; chk("R2 order", 32'(co_data), 32'(16'h1000 + 16'(i)));
      tick("R2 level");
    end
    // R8: idle & empty with low mark set -> quiet; busy -> aempty
    idle_ins(); busy = 0;
    set_cfg(16'h0005);
    chk("R8 idle quiet", 32'({drq_tx, sts_aempty}), 0);
    busy = 1; #1;
    chk("R6 aempty when busy", 32'(sts_aempty), 1);
    // R9: enable tx dma -> request instead of flag
    set_cfg(16'h0085);
    chk("R9 tx dma", 32'({drq_tx, sts_aempty}), 32'b10);
    // R4: host read ignored in tx direction
    hw_valid = 1; hw_data = 16'hBEEF; tick("R2 level");
    idle_ins(); hr_req = 1; tick("R4 read ignored in tx");
    chk("R4 level after ignored read", 32'(level), 1);
    idle_ins(); co_ready = 1; tick("R2 level");
    // R10: empty host read -> stale head, pulse
    idle_ins(); dir_rx = 1; hr_req = 1; tick("R10 level");
    chk("R10 pulse", 32'(hr_underrun), 1);
    chk("R10 stale head", 32'(hr_data), 32'(m_mem[m_start]));
    idle_ins(); tick("R10 level");
    chk("R10 pulse ends", 32'(hr_underrun), 0);
    // R11: simultaneous push and pop
    ci_valid = 1; ci_data = 16'h0A0A; tick("R2 level");
    ci_data = 16'h0B0B; tick("R2 level");
    hr_req = 1; ci_data = 16'h0C0C; tick("R11 level");
    chk("R11 level same", 32'(level), 2);
    chk("R11 head advanced", 32'(hr_data), 32'h0B0B);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      idle_ins();
      if ($urandom_range(0, 99) < 3) begin
        cfg_word = 16'($urandom());
        cfg_wr = 1;
      end
      if ($urandom_range(0, 99) < 2) dir_rx = ~dir_rx;
      busy     = ($urandom_range(0, 9) != 0);
      hw_valid = $urandom_range(0, 1);
      hw_data  = 16'($urandom());
      ci_valid = $urandom_range(0, 1);
      ci_data  = 16'($urandom());
      hr_req   = ($urandom_range(0, 2) == 0);
      co_ready = ($urandom_range(0, 2) == 0);
      tick("R2 level");
    end
    idle_ins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule